// File: doc/BRIEF.md
# Rotate-and-Mask Shift Unit

This unit carries out the shift and rotate operations of a 64-bit integer datapath that numbers bits big-endian, so index 0 is the most significant bit. Every operation runs through one shared path. An operand-forming stage chooses what gets rotated, how far, and which mask window applies. A logarithmic left rotator and a window mask generator then do the work. A final merge picks, for each bit, either the rotated value or a fill value. The fill is the insert destination, copies of the sign bit, or zero.

Decode logic supplies an operation code and the operands: the source, an insert destination, a 7-bit shift amount (an immediate or the low bits of a register), and two 6-bit mask indices. The answer comes back registered one cycle later under `out_valid`, with a 64-bit result and two carry flags. Only the arithmetic right word shift sets the carry flags.

Top module: `rotmask_unit`

## Requirements
- R1: The `op` encodings are: 0 word rotate-and-mask, 1 word rotate-and-insert, 2 doubleword clear-left, 3 doubleword clear-right, 4 doubleword clear-both, 5 doubleword shift left, 6 word shift left, 7 arithmetic right word shift, 8 sign-extend-word-then-shift-left. Word rotate (0) rotates the low 32 bits of `src` left by `amt[4:0]`, with the word copied into both halves. It then keeps the big-endian positions 32+`mb[4:0]` through 32+`me[4:0]` and clears all other bits.
- R2: Word rotate-and-insert (1) rotates and builds its mask as in R1. Bits inside the mask take the rotated value, and bits outside the mask keep `dst`.
- R3: When the begin index is greater than the end index, the mask wraps: it covers begin..63 and 0..end.
- R4: The doubleword forms rotate the whole of `src` left by `amt[5:0]`. Clear-left (2) keeps `mb`..63, clear-right (3) keeps 0..`me`, and clear-both (4) keeps `mb`..63-`amt[5:0]`.
- R5: Doubleword shift left (5) shifts `src` left by `amt[5:0]`. When `amt[6]` is 1 the result is 0.
- R6: Word shift left (6) shifts the low word left by `amt[4:0]` and zeroes the upper 32 bits. When `amt[5]` is 1 the result is 0, and `amt[6]` is ignored.
- R7: Arithmetic right word shift (7) shifts the low word right by `amt[5:0]`, filling with bit 31 of `src`, and sign-extends the result to 64 bits. Amounts of 32 to 63 give 64 copies of the sign.
- R8: For op 7, `ca` and `ca32` are both 1 exactly when bit 31 of `src` is 1 and at least one 1 bit is shifted out of the word.
- R9: Op 8 sign-extends bit 31 of `src` (big-endian bit 32) across the upper half, then shifts left by `amt[5:0]`.
- R10: Every op other than 7 drives `ca` and `ca32` to 0. Codes 9 to 15 give a result of 0.
- R11: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high, and that is when the result and carries appear. Without `in_valid`, the outputs hold their values.
- R12: While `rst_n` is low, `out_valid`, `result`, `ca` and `ca32` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and op are valid this cycle |
| op | input | 4 | Operation code (R1) |
| src | input | 64 | Source operand |
| dst | input | 64 | Insert destination operand |
| amt | input | 7 | Shift or rotate amount |
| mb | input | 6 | Mask begin index (big-endian) |
| me | input | 6 | Mask end index (big-endian) |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered result |
| ca | output | 1 | 64-bit carry of arithmetic right shift |
| ca32 | output | 1 | 32-bit carry of arithmetic right shift |

## Verification
All operations share one rotator and one mask generator, so a fault in either shows up across many op codes at once. A wrong rotate stage corrupts specific bit groups in every rotating op. A wrong mask-window or wrap decision leaves stray or missing bits next to the mask edges. A wrong fill selection shows up as bad upper halves on the arithmetic shift or wrong outside-mask bits on inserts. Every such fault reaches `result` in the cycle right after the input cycle, because the path holds only one register. A wrong carry term shows up on `ca` and `ca32` in that same cycle.

// File: rtl/rm_pkg.sv
package rm_pkg;
  localparam int XLEN = 64;
  localparam int HALF = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);

  typedef enum logic [3:0] {
    OP_WROT = 4'd0,
    OP_WINS = 4'd1,
    OP_DCL  = 4'd2,
    OP_DCR  = 4'd3,
    OP_DCB  = 4'd4,
    OP_SLD  = 4'd5,
    OP_SLW  = 4'd6,
    OP_SRAW = 4'd7,
    OP_EXSL = 4'd8
  } rm_op_e;
endpackage

// File: rtl/rm_rotator.sv
module rm_rotator #(
  parameter int W  = 64,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] sh,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [AW+1];

  assign stage[0] = din;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = sh[s] ? {stage[s][W-1-STEP:0], stage[s][W-1:W-STEP]}
                              : stage[s];
  end

  assign dout = stage[AW];
endmodule

// File: rtl/rm_maskgen.sv
module rm_maskgen #(
  parameter int W  = 64,
  parameter int AW = $clog2(W)
) (
  input  logic [AW-1:0] beg_i,
  input  logic [AW-1:0] end_i,
  input  logic          kill,
  output logic [W-1:0]  mask
);
  logic wrap;
  assign wrap = beg_i > end_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [AW-1:0] IDX = AW'(i);
    logic ge_b, le_e;
    assign ge_b = IDX >= beg_i;
    assign le_e = IDX <= end_i;
    // big-endian index i lives at little-endian bit W-1-i
    assign mask[W-1-i] = !kill && (wrap ? (ge_b || le_e) : (ge_b && le_e));
  end
endmodule

// File: rtl/rm_ctrl.sv
module rm_ctrl
  import rm_pkg::*;
(
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] dst,
  input  logic [SHW:0]    amt,
  input  logic [SHW-1:0]  mb,
  input  logic [SHW-1:0]  me,
  output logic [XLEN-1:0] rot_in,
  output logic [SHW-1:0]  rot_sh,
  output logic [SHW-1:0]  m_beg,
  output logic [SHW-1:0]  m_end,
  output logic            m_kill,
  output logic [XLEN-1:0] fill,
  output logic            is_sra
);
  localparam logic [SHW-1:0] TOP   = SHW'(XLEN - 1);
  localparam logic [SHW-1:0] HBASE = SHW'(HALF);

  logic [HALF-1:0] word;
  logic [SHW-1:0]  wsh;
  logic [SHW-1:0]  dsh;
  logic [SHW-1:0]  wmb;
  logic [SHW-1:0]  wme;
  logic            sgn;

  assign word = src[HALF-1:0];
  assign sgn  = word[HALF-1];
  assign wsh  = {1'b0, amt[SHW-2:0]};
  assign dsh  = amt[SHW-1:0];
  assign wmb  = {1'b1, mb[SHW-2:0]};
  assign wme  = {1'b1, me[SHW-2:0]};

  always_comb begin
    rot_in = {word, word};
    rot_sh = wsh;
    m_beg  = wmb;
    m_end  = wme;
    m_kill = 1'b0;
    fill   = '0;
    is_sra = 1'b0;
    case (rm_op_e'(op))
      OP_WROT: ;
      OP_WINS: fill = dst;
      OP_DCL: begin
        rot_in = src;
        rot_sh = dsh;
        m_beg  = mb;
        m_end  = TOP;
      end
      OP_DCR: begin
        rot_in = src;
        rot_sh = dsh;
        m_beg  = '0;
        m_end  = me;
      end
      OP_DCB: begin
        rot_in = src;
        rot_sh = dsh;
        m_beg  = mb;
        m_end  = TOP - dsh;
      end
      OP_SLD: begin
        rot_in = src;
        rot_sh = dsh;
        m_beg  = '0;
        m_end  = TOP - dsh;
        m_kill = amt[SHW];
      end
      OP_SLW: begin
        m_beg  = HBASE;
        m_end  = TOP - wsh;
        m_kill = amt[SHW-1];
      end
      OP_SRAW: begin
        rot_sh = HBASE - wsh;
        m_beg  = HBASE + wsh;
        m_end  = TOP;
        m_kill = amt[SHW-1];
        fill   = {XLEN{sgn}};
        is_sra = 1'b1;
      end
      OP_EXSL: begin
        rot_in = {{HALF{sgn}}, word};
        rot_sh = dsh;
        m_beg  = '0;
        m_end  = TOP - dsh;
      end
      default: m_kill = 1'b1;
    endcase
  end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [3:0]      op,
  input  logic [63:0]     src,
  input  logic [63:0]     dst,
  input  logic [6:0]      amt,
  input  logic [5:0]      mb,
  input  logic [5:0]      me,
  output logic            out_valid,
  output logic [63:0]     result,
  output logic            ca,
  output logic            ca32
);
  logic [XLEN-1:0] rot_in, rot_out, fill, mask;
  logic [SHW-1:0]  rot_sh, m_beg, m_end;
  logic            m_kill, is_sra;

  rm_ctrl u_ctrl (
    .op(op), .src(src), .dst(dst), .amt(amt), .mb(mb), .me(me),
    .rot_in(rot_in), .rot_sh(rot_sh), .m_beg(m_beg), .m_end(m_end),
    .m_kill(m_kill), .fill(fill), .is_sra(is_sra)
  );

  rm_rotator #(.W(XLEN)) u_rot (
    .din(rot_in), .sh(rot_sh), .dout(rot_out)
  );

  rm_maskgen #(.W(XLEN)) u_mask (
    .beg_i(m_beg), .end_i(m_end), .kill(m_kill), .mask(mask)
  );

  // next-state
  logic [XLEN-1:0] res_d;
  logic            lost, car_d;

  always_comb begin
    res_d = (rot_out & mask) | (fill & ~mask);
    lost  = |(rot_out[HALF-1:0] & ~mask[HALF-1:0]);
    car_d = is_sra && src[HALF-1] && lost;
  end

  // registers
  logic [XLEN-1:0] res_q;
  logic            vld_q, ca_q, ca32_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      res_q  <= '0;
      ca_q   <= 1'b0;
      ca32_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q  <= res_d;
        ca_q   <= car_d;
        ca32_q <= car_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign ca        = ca_q;
  assign ca32      = ca32_q;
endmodule

// File: rtl/rotmask_unit_chk.sv
module rotmask_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [3:0]  op,
  input logic [63:0] src,
  input logic [6:0]  amt,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        ca,
  input logic        ca32
);
  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(ca) && $stable(ca32)));
  assert_no_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != 4'd7) |=> (!ca && !ca32));
  assert_pos_no_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd7 && !src[31]) |=> (!ca && !ca32));
  assert_sld_kill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd5 && amt[6]) |=> (result == 64'd0));
  assert_slw_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd6) |=> (result[63:32] == 32'd0));
  assert_sra_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd7) |=> (result[63:32] == {32{result[31]}}));
  assert_reset_R12: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && result == 64'd0 && !ca && !ca32));
endmodule

bind rotmask_unit rotmask_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .src(src),
  .amt(amt), .out_valid(out_valid), .result(result), .ca(ca), .ca32(ca32)
);

// File: tb/rotmask_unit_bench.sv
`timescale 1ns/1ps
module rotmask_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [63:0] src = '0, dst = '0;
  logic [6:0]  amt = '0;
  logic [5:0]  mb = '0, me = '0;
  logic        out_valid, ca, ca32;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  logic [63:0] last_res = '0;
  logic        last_ca = 1'b0;

  always #4 clk = ~clk;

  rotmask_unit u_rotmask_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .src(src),
    .dst(dst), .amt(amt), .mb(mb), .me(me), .out_valid(out_valid),
    .result(result), .ca(ca), .ca32(ca32)
  );

  function automatic logic [63:0] bemask(input int b, input int e);
    logic [63:0] m = '0;
    for (int i = 0; i < 64; i++)
      if ((b <= e) ? (i >= b && i <= e) : (i >= b || i <= e)) m[63-i] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] rotl(input logic [63:0] x, input int n);
    return (n == 0) ? x : ((x << n) | (x >> (64 - n)));
  endfunction

  function automatic logic [63:0] ref_res(input logic [3:0] o, input logic [63:0] s,
      input logic [63:0] d, input logic [6:0] a, input logic [5:0] b, input logic [5:0] e);
    logic [31:0] w = s[31:0];
    logic [63:0] r, m;
    int n;
    case (o)
      4'd0, 4'd1: begin
        r = rotl({w, w}, int'(a[4:0]));
        m = bemask(32 + int'(b[4:0]), 32 + int'(e[4:0]));
        return (o == 4'd0) ? (r & m) : ((r & m) | (d & ~m));
      end
      4'd2: return rotl(s, int'(a[5:0])) & bemask(int'(b), 63);
      4'd3: return rotl(s, int'(a[5:0])) & bemask(0, int'(e));
      4'd4: return rotl(s, int'(a[5:0])) & bemask(int'(b), 63 - int'(a[5:0]));
      4'd5: return a[6] ? 64'd0 : (s << a[5:0]);
      4'd6: begin
        logic [31:0] t = w << a[4:0];
        return a[5] ? 64'd0 : {32'd0, t};
      end
      4'd7: begin
        n = int'(a[5:0]);
        return 64'($signed({{32{w[31]}}, w}) >>> n);
      end
      4'd8: return {{32{w[31]}}, w} << a[5:0];
      default: return 64'd0;
    endcase
  endfunction

  function automatic logic ref_ca(input logic [3:0] o, input logic [63:0] s, input logic [6:0] a);
    logic [31:0] w = s[31:0];
    logic lost;
    if (o != 4'd7) return 1'b0;
    if (a[5]) lost = (w != 0);
    else lost = ((w & ((32'd1 << a[4:0]) - 32'd1)) != 0);
    return w[31] && lost;
  endfunction

  function automatic string op_tag(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at a negedge with in_valid low
  task automatic run_vec(input string tag, input logic [3:0] o, input logic [63:0] s,
      input logic [63:0] d, input logic [6:0] a, input logic [5:0] b, input logic [5:0] e);
    logic [63:0] er = ref_res(o, s, d, a, b, e);
    logic        ec = ref_ca(o, s, a);
    op = o; src = s; dst = d; amt = a; mb = b; me = e; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11", 64'(out_valid), 64'd1);
    chk(tag, result, er);
    chk((o == 4'd7) ? "R8" : "R10", {62'd0, ca, ca32}, {62'd0, ec, ec});
    last_res = er;
    last_ca  = ec;
  endtask

  task automatic idle_cycle();
    src = {$urandom, $urandom};
    op  = 4'($urandom);
    @(posedge clk);
    @(negedge clk);
    chk("R11", 64'(out_valid), 64'd0);
    chk("R11", {result[63:1], result[0] ^ ca}, {last_res[63:1], last_res[0] ^ last_ca});
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    repeat (3) @(negedge clk);
    chk("R12", {result[63:2], out_valid ^ result[1], ca ^ ca32 ^ result[0]}, 64'd0);
    chk("R12", {62'd0, ca, ca32}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corner cases
    run_vec("R1", 4'd0, 64'hf1110001, 0, 7'd1, 6'd0, 6'd30);
    run_vec("R1", 4'd0, 64'h8fffffff, 0, 7'd1, 6'd31, 6'd31);
    run_vec("R1", 4'd0, 64'hebeb1888, 0, 7'd0, 6'd16, 6'd31);
    run_vec("R1", 4'd0, 64'h111, 0, 7'd33, 6'd0, 6'd31);
    run_vec("R1", 4'd0, 64'hfebaacda, 0, 7'd16, 6'd8, 6'd11);
    run_vec("R2", 4'd1, 64'hcc, 64'h7f00ffff, 7'd16, 6'd8, 6'd15);
    run_vec("R2", 4'd1, 64'h1, 64'h7fffffff, 7'd31, 6'd0, 6'd0);
    run_vec("R3", 4'd0, 64'h12345678, 0, 7'd0, 6'd28, 6'd3);
    run_vec("R3", 4'd4, 64'h0123456789abcdef, 0, 7'd40, 6'd50, 6'd0);
    run_vec("R4", 4'd2, 64'h1000dead0000111c, 0, 7'd32, 6'd47, 6'd0);
    run_vec("R4", 4'd3, 64'h0100ffffe0000111, 0, 7'd16, 6'd0, 6'd15);
    run_vec("R4", 4'd4, 64'h0100ffff00000111, 0, 7'd8, 6'd31, 6'd0);
    run_vec("R5", 4'd5, 64'hffffffffffffffff, 0, 7'd64, 6'd0, 6'd0);
    run_vec("R5", 4'd5, 64'h8000000000000000, 0, 7'd0, 6'd0, 6'd0);
    run_vec("R5", 4'd5, 64'h8000000000000001, 0, 7'd63, 6'd0, 6'd0);
    run_vec("R6", 4'd6, 64'hffffffff80000000, 0, 7'h40, 6'd0, 6'd0);
    run_vec("R6", 4'd6, 64'h1, 0, 7'd32, 6'd0, 6'd0);
    run_vec("R7", 4'd7, 64'h82345678, 0, 7'd8, 6'd0, 6'd0);
    run_vec("R7", 4'd7, 64'h12345678, 0, 7'd8, 6'd0, 6'd0);
    run_vec("R8", 4'd7, 64'h80000000, 0, 7'd31, 6'd0, 6'd0);
    run_vec("R8", 4'd7, 64'h80000100, 0, 7'd40, 6'd0, 6'd0);
    run_vec("R7", 4'd7, 64'h7fffffff, 0, 7'd0, 6'd0, 6'd0);
    run_vec("R9", 4'd8, 64'h0000010180122900, 0, 7'd0, 6'd0, 6'd0);
    run_vec("R9", 4'd8, 64'h5678, 0, 7'd31, 6'd0, 6'd0);
    run_vec("R9", 4'd8, 64'h3ffffd7377f19fdd, 0, 7'd7, 6'd0, 6'd0);
    run_vec("R10", 4'd12, 64'hffffffffffffffff, 64'h5, 7'd3, 6'd1, 6'd2);
    idle_cycle();

    // constrained random
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] o = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % 9);
      run_vec(op_tag(o), o, {$urandom, $urandom}, {$urandom, $urandom},
              7'($urandom), 6'($urandom), 6'($urandom));
      if ($urandom % 4 == 0) idle_cycle();
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule